// File: doc/BRIEF.md
# Configurable Serial Shift Data Port

This block moves words between a parallel stream interface and a pair of serial pins. The transmit side takes a word on a valid/ready handshake, waits for a frame strobe on its bit clock, and then drives the word onto the serial output one bit per bit-clock period. The receive side waits for its own frame strobe, samples the serial input on later bit-clock rising edges, and offers the assembled word on a valid/ready output. The two directions have independent bit clocks and frame strobes. These may come from outside the chip or from a clock generator next to the block.

Both bit clocks are slow compared with the system clock `clk`. They are sampled and edge-detected in the `clk` domain, so a bit-clock or strobe level must be held for at least two `clk` cycles. Word length is 8 or 16 bits, chosen separately for each direction. Bit order is shared by both directions. The serial output can launch on the rising edge, or half a bit period later on the falling edge, which gives more hold time. Length and order are captured when a word starts, so changing them mid-word does not disturb that word.

Back-pressure rules. The transmit side holds a single word. `tx_ready` stays high until a word is accepted, stays low until a frame start moves that word into the shifter, and then rises again. The receive side cannot stall the serial line. A received word stays on `rx_data` while `rx_valid` is high and `rx_ready` is low. A newer completed word replaces it.

Top module: `serial_shift_port`

## Requirements
- R1: While reset is held and directly after it, `sd_out` is 0, `tx_ready` is 1, `rx_valid` is 0 and `rx_data` is 0.
- R2: A transmit word is accepted in a `clk` cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` then stays 0 until a frame start captures the word, and is 1 again in the cycle after that capture.
- R3: A frame start happens when `tx_frame` is high at a `tx_bclk` rising edge while the shifter is idle or is launching its last bit, and a word is held. The first bit is launched at the next rising edge. A strobe with no word held is ignored and `sd_out` keeps its value.
- R4: `cfg_msb_first` = 0 sends and receives the least significant bit first. A value of 1 sends and receives the most significant bit of the active length first. The value is captured at each word start.
- R5: `cfg_tx_len8` = 0 sends all 16 bits. A value of 1 sends only bits 7..0 of the held word.
- R6: `cfg_out_delay` = 0 updates `sd_out` on the `tx_bclk` rising edge that launches a bit. A value of 1 holds the update until the next falling edge.
- R7: Between words, `sd_out` keeps the last bit it sent, and it changes only on a `tx_bclk` edge.
- R8: `rx_frame` high at a `rx_bclk` rising edge, while receive is idle or taking its last bit, starts a word. Bits are sampled on the following rising edges, and falling edges never complete a word. With `cfg_rx_len8` = 1, the 8 received bits land in `rx_data[7:0]` and bits 15..8 are 0. With `cfg_rx_len8` = 0, all 16 bits are used.
- R9: `rx_valid` rises in the cycle after the last bit is sampled. `rx_data` is held while `rx_valid` is high and `rx_ready` is low, `rx_valid` clears after a cycle with `rx_ready` high, and a newer completed word overwrites the held one.
- R10: The transmit and receive paths run at the same time on unrelated bit clocks without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_msb_first | input | 1 | Bit order for both directions |
| cfg_tx_len8 | input | 1 | Transmit word length, 1 selects 8 bits |
| cfg_rx_len8 | input | 1 | Receive word length, 1 selects 8 bits |
| cfg_out_delay | input | 1 | Launch serial output on the falling edge |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_frame | input | 1 | Transmit frame strobe |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit holding register empty |
| tx_data | input | 16 | Transmit word |
| sd_out | output | 1 | Serial data out |
| rx_bclk | input | 1 | Receive bit clock |
| rx_frame | input | 1 | Receive frame strobe |
| sd_in | input | 1 | Serial data in |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the received word |
| rx_data | output | 16 | Received word |

## Verification
Some properties hold on every cycle, and the assertions check those. They check that `sd_out` moves only on a bit-clock edge and never on a rising edge in delayed mode. They check that an accepted word drops `tx_ready`, that `tx_ready` only returns after a frame edge, that a completed word sets `rx_valid`, that a stalled word stays stable, and that short received words have a zero upper byte. Other behaviour can only be shown by the bench scenarios. These are the order of bits on the wire in each length and order combination, strobes that arrive with nothing to send, back-to-back framing on the last-bit edge, overwriting of an unread word, and the two directions running at different rates. The bench's reference model covers these on every clock.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef struct packed {
    logic msb_first;
    logic len8;
  } ssp_fmt_t;
endpackage

// File: rtl/ssp_edge_det.sv
module ssp_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise,
  output logic fall
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig;
  end

  assign rise = sig & ~sig_q;
  assign fall = ~sig & sig_q;
endmodule

// File: rtl/ssp_tx_path.sv
module ssp_tx_path
  import ssp_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_rise,
  input  logic              bclk_fall,
  input  logic              frame,
  input  logic              cfg_msb_first,
  input  logic              cfg_len8,
  input  logic              cfg_out_delay,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              dout
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(SHORT_W);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  logic [WORD_W-1:0] hold_q, sh_q;
  logic              hold_full_q;
  logic [CNT_W-1:0]  rem_q;
  ssp_fmt_t          fmt_q;
  logic              pend_q, dout_q;
  logic              start, launch, next_bit;
  logic [WORD_W-1:0] load_word;

  assign start    = bclk_rise & frame & (rem_q <= ONE) & hold_full_q;
  assign launch   = bclk_rise & (rem_q != '0);
  assign next_bit = fmt_q.msb_first ? (fmt_q.len8 ? sh_q[SHORT_W-1] : sh_q[WORD_W-1])
                                    : sh_q[0];
  assign load_word = cfg_len8 ? {{(WORD_W-SHORT_W){1'b0}}, hold_q[SHORT_W-1:0]} : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      sh_q        <= '0;
      rem_q       <= '0;
      fmt_q       <= '0;
      pend_q      <= 1'b0;
      dout_q      <= 1'b0;
    end else begin
      if (launch) begin
        pend_q <= next_bit;
        if (!cfg_out_delay) dout_q <= next_bit;
        sh_q  <= fmt_q.msb_first ? (sh_q << 1) : (sh_q >> 1);
        rem_q <= rem_q - ONE;
      end else if (bclk_fall && cfg_out_delay) begin
        dout_q <= pend_q;
      end
      if (start) begin
        sh_q            <= load_word;
        rem_q           <= cfg_len8 ? LEN_SHORT : LEN_LONG;
        fmt_q.msb_first <= cfg_msb_first;
        fmt_q.len8      <= cfg_len8;
        hold_full_q     <= 1'b0;
      end
      if (tx_valid && !hold_full_q) begin
        hold_q      <= tx_data;
        hold_full_q <= 1'b1;
      end
    end
  end

  assign tx_ready = ~hold_full_q;
  assign dout     = dout_q;

  p_accept_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
  p_empty_after_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> $past(bclk_rise && frame));
  p_quiet_between_edges_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bclk_rise && !bclk_fall) |=> $stable(dout));
  p_delay_rise_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_rise && cfg_out_delay) |=> $stable(dout));
endmodule

// File: rtl/ssp_rx_path.sv
module ssp_rx_path
  import ssp_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_rise,
  input  logic              bclk_fall,
  input  logic              frame,
  input  logic              din,
  input  logic              cfg_msb_first,
  input  logic              cfg_len8,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(SHORT_W);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  logic [WORD_W-1:0] sh_q, sh_next, word;
  logic [CNT_W-1:0]  rem_q;
  ssp_fmt_t          fmt_q;
  logic              take, last, start;
  logic              valid_q;
  logic [WORD_W-1:0] data_q;

  assign take  = bclk_rise & (rem_q != '0);
  assign last  = take & (rem_q == ONE);
  assign start = bclk_rise & frame & (rem_q <= ONE);

  assign sh_next = fmt_q.msb_first ? {sh_q[WORD_W-2:0], din} : {din, sh_q[WORD_W-1:1]};

  always_comb begin
    if (!fmt_q.len8)          word = sh_next;
    else if (fmt_q.msb_first) word = {{(WORD_W-SHORT_W){1'b0}}, sh_next[SHORT_W-1:0]};
    else                      word = {{(WORD_W-SHORT_W){1'b0}}, sh_next[WORD_W-1 -: SHORT_W]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      rem_q   <= '0;
      fmt_q   <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (take) begin
        sh_q  <= sh_next;
        rem_q <= rem_q - ONE;
      end
      if (start) begin
        sh_q            <= '0;
        rem_q           <= cfg_len8 ? LEN_SHORT : LEN_LONG;
        fmt_q.msb_first <= cfg_msb_first;
        fmt_q.len8      <= cfg_len8;
      end
      if (last) begin
        valid_q <= 1'b1;
        data_q  <= word;
      end else if (rx_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign rx_valid = valid_q;
  assign rx_data  = data_q;

  p_done_sets_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> rx_valid);
  p_stall_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !last) |=> (rx_valid && $stable(rx_data)));
  p_short_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (last && fmt_q.len8) |=> (rx_data[WORD_W-1:SHORT_W] == '0));
  p_no_fall_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_fall |=> !$rose(rx_valid));
endmodule

// File: rtl/serial_shift_port.sv
module serial_shift_port #(
  parameter int WORD_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_msb_first,
  input  logic              cfg_tx_len8,
  input  logic              cfg_rx_len8,
  input  logic              cfg_out_delay,
  input  logic              tx_bclk,
  input  logic              tx_frame,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              sd_out,
  input  logic              rx_bclk,
  input  logic              rx_frame,
  input  logic              sd_in,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_data
);
  logic tx_rise, tx_fall, rx_rise, rx_fall;

  ssp_edge_det u_tx_edge (.clk(clk), .rst_n(rst_n), .sig(tx_bclk), .rise(tx_rise), .fall(tx_fall));
  ssp_edge_det u_rx_edge (.clk(clk), .rst_n(rst_n), .sig(rx_bclk), .rise(rx_rise), .fall(rx_fall));

  ssp_tx_path #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .bclk_rise(tx_rise), .bclk_fall(tx_fall), .frame(tx_frame),
    .cfg_msb_first(cfg_msb_first), .cfg_len8(cfg_tx_len8), .cfg_out_delay(cfg_out_delay),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .dout(sd_out)
  );

  ssp_rx_path #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .bclk_rise(rx_rise), .bclk_fall(rx_fall), .frame(rx_frame),
    .din(sd_in), .cfg_msb_first(cfg_msb_first), .cfg_len8(cfg_rx_len8),
    .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data)
  );
endmodule

// File: tb/serial_shift_port_tb_top.sv
`timescale 1ns/1ps
module serial_shift_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_msb_first = 0, cfg_tx_len8 = 0, cfg_rx_len8 = 0, cfg_out_delay = 0;
  logic tx_bclk = 0, tx_frame = 0, tx_valid = 0;
  logic [15:0] tx_data = '0;
  logic rx_bclk = 0, rx_frame = 0, sd_in = 0, rx_ready = 0;
  logic tx_ready, sd_out, rx_valid;
  logic [15:0] rx_data;

  int n_chk = 0, n_fail = 0;
  bit chk_en = 0, done = 0;

  always #2 clk = ~clk;

  serial_shift_port dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_msb_first(cfg_msb_first), .cfg_tx_len8(cfg_tx_len8),
    .cfg_rx_len8(cfg_rx_len8), .cfg_out_delay(cfg_out_delay), .tx_bclk(tx_bclk),
    .tx_frame(tx_frame), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .sd_out(sd_out), .rx_bclk(rx_bclk), .rx_frame(rx_frame), .sd_in(sd_in),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  bit m_prev_tx, m_prev_rx, m_full, m_pend, m_dout, m_rxv;
  logic [15:0] m_hold, m_rxd;
  bit tq[$];
  bit rq[$];
  int r_rem, r_n;
  bit r_msb;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev_tx = 0; m_prev_rx = 0; m_full = 0; m_pend = 0; m_dout = 0;
      m_rxv = 0; m_hold = '0; m_rxd = '0; tq.delete(); rq.delete(); r_rem = 0;
      r_n = 16; r_msb = 0;
    end else begin
      automatic bit old_full = m_full;
      automatic int old_rem = tq.size();
      automatic bit done_w = 0;
      automatic int old_r = r_rem;
      if (tx_bclk && !m_prev_tx) begin
        if (old_rem > 0) begin
          automatic bit b = tq.pop_front();
          m_pend = b;
          if (!cfg_out_delay) m_dout = b;
        end
        if (tx_frame && old_rem <= 1 && old_full) begin
          automatic int n = cfg_tx_len8 ? 8 : 16;
          tq.delete();
          for (int i = 0; i < n; i++) tq.push_back(m_hold[cfg_msb_first ? n-1-i : i]);
          m_full = 0;
        end
      end else if (!tx_bclk && m_prev_tx && cfg_out_delay) begin
        m_dout = m_pend;
      end
      if (tx_valid && !old_full) begin m_hold = tx_data; m_full = 1; end
      m_prev_tx = tx_bclk;

      if (rx_bclk && !m_prev_rx) begin
        if (old_r > 0) begin
          rq.push_back(sd_in);
          r_rem--;
          if (r_rem == 0) begin
            automatic logic [15:0] v = '0;
            for (int i = 0; i < r_n; i++) begin
              if (r_msb) v = {v[14:0], rq[i]};
              else       v[i] = rq[i];
            end
            m_rxd = v; done_w = 1;
          end
        end
        if (rx_frame && old_r <= 1) begin
          r_rem = cfg_rx_len8 ? 8 : 16; r_n = r_rem; r_msb = cfg_msb_first; rq.delete();
        end
      end
      if (done_w) m_rxv = 1;
      else if (rx_ready) m_rxv = 0;
      m_prev_rx = rx_bclk;
    end
  end

  always @(negedge clk) begin
    if (chk_en && !done) begin
      chk(sd_out === m_dout, "R3 R4 R5 R6 R7 sd_out", sd_out, m_dout);
      chk(tx_ready === !m_full, "R2 tx_ready", tx_ready, !m_full);
      chk(rx_valid === m_rxv, "R9 rx_valid", rx_valid, m_rxv);
      chk(rx_data === m_rxd, "R8 R9 rx_data", rx_data, m_rxd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tx_write(input logic [15:0] d);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1; tx_data = d;
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic tx_run(input int cycles, input int sa, input int sb, input int half);
    @(negedge clk);
    for (int k = 0; k < cycles; k++) begin
      tx_bclk = 1; tx_frame = (k == sa || k == sb);
      repeat (half) @(negedge clk);
      tx_bclk = 0; tx_frame = 0;
      repeat (half) @(negedge clk);
    end
  endtask

  task automatic rx_send(input logic [15:0] w, input int n, input bit msb, input int half);
    @(negedge clk);
    for (int k = 0; k <= n; k++) begin
      rx_bclk = 1; rx_frame = (k == 0);
      repeat (half) @(negedge clk);
      rx_bclk = 0; rx_frame = 0;
      if (k < n) sd_in = w[msb ? n-1-k : k];
      repeat (half) @(negedge clk);
    end
  endtask

  task automatic rx_take();
    @(negedge clk); rx_ready = 1;
    @(negedge clk); rx_ready = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(sd_out == 0 && tx_ready == 1 && rx_valid == 0 && rx_data == 0, "R1 reset outputs",
        {sd_out, tx_ready, rx_valid}, 3'b010);
    rst_n = 1;
    @(negedge clk);
    chk(sd_out == 0 && tx_ready == 1 && rx_valid == 0, "R1 after release",
        {sd_out, tx_ready, rx_valid}, 3'b010);
    chk_en = 1;

    // LSB first, 16-bit, rising launch
    tx_write(16'hA5C3);
    tx_run(18, 0, -1, 3);
    // MSB first, 8-bit, falling launch
    cfg_msb_first = 1; cfg_tx_len8 = 1; cfg_out_delay = 1;
    tx_write(16'h3C96);
    tx_run(11, 0, -1, 3);
    // strobe with nothing held: ignored, output keeps last bit
    tx_run(6, 0, 3, 3);
    // back-to-back framing on the last-bit edge, 16-bit MSB first, rising launch
    cfg_tx_len8 = 0; cfg_out_delay = 0;
    tx_write(16'h8001);
    fork
      tx_run(36, 0, 16, 3);
      tx_write(16'h7E5A);
    join

    // receive LSB first, 16 bits
    cfg_msb_first = 0; cfg_rx_len8 = 0;
    rx_send(16'h1234, 16, 0, 3);
    repeat (2) @(negedge clk);
    chk(rx_valid && rx_data == 16'h1234, "R4 rx lsb-first word", rx_data, 16'h1234);
    rx_take();
    @(negedge clk);
    chk(!rx_valid, "R9 cleared after ready", rx_valid, 0);
    // receive MSB first, 8 bits
    cfg_msb_first = 1; cfg_rx_len8 = 1;
    rx_send(16'hFFB7, 8, 1, 3);
    repeat (2) @(negedge clk);
    chk(rx_valid && rx_data == 16'h00B7, "R8 rx short word", rx_data, 16'h00B7);
    rx_take();
    // overwrite of an unread word
    cfg_msb_first = 0; cfg_rx_len8 = 1;
    rx_send(16'h0011, 8, 0, 2);
    rx_send(16'h00C4, 8, 0, 2);
    repeat (2) @(negedge clk);
    chk(rx_valid && rx_data == 16'h00C4, "R9 newer word overwrites", rx_data, 16'h00C4);
    rx_take();

    // both directions together, unrelated rates
    cfg_msb_first = 0; cfg_tx_len8 = 0; cfg_rx_len8 = 0; cfg_out_delay = 1;
    tx_write(16'hBEEF);
    fork
      tx_run(18, 0, -1, 3);
      rx_send(16'h6A39, 16, 0, 5);
    join
    repeat (2) @(negedge clk);
    chk(rx_valid && rx_data == 16'h6A39, "R10 rx during tx", rx_data, 16'h6A39);
    rx_take();
    repeat (10) @(negedge clk);
    chk(tx_ready, "R10 tx drained", tx_ready, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule